// File: doc/BRIEF.md
# Host-DSP Doorbell Register Block

This block carries the flag handshake between a host processor and a DSP core. There are two 64-bit doorbells, one for each direction. The most significant bit of a doorbell is a BUSY flag: the sender sets it when it posts a message. The bit below it is a DONE flag: the receiver sets it to acknowledge. All lower bits hold a message header. Each side has its own small status register and its own mask register. A side's interrupt output is a level signal. It is high while any unmasked status source of that side is set.

Each side has one register port. The port has a write enable, an address and write data, and its read data follows the address combinationally. A write to a register lands on the rising clock edge where the enable is high, and the new value is visible on reads and on the interrupt outputs right after that edge. In the usual flow, the receiver masks its source, handles the message, updates the doorbell flags, and then unmasks the source again. Mailbox memory and payload decoding are not part of this block.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset every register reads zero on both ports and both interrupt outputs are low.
- R2: Address map, shared by both ports: host status 0x18, DSP status 0x20, host mask 0x28, DSP mask 0x30, host-to-DSP doorbell 0x38, DSP-to-host doorbell 0x40. Either port reads every register. Both status registers are read-only. Any other address reads zero, and a write to it changes nothing.
- R3: A doorbell stores the full 64-bit word written to it, with BUSY at bit 63, DONE at bit 62 and the header in bits 61:0. Both ports may write either doorbell. A doorbell holds its value in any cycle with no write to it.
- R4: Host status reads bit 0 = DONE of the host-to-DSP doorbell and bit 1 = BUSY of the DSP-to-host doorbell. All its other bits are zero.
- R5: DSP status reads bit 0 = DONE of the DSP-to-host doorbell and bit 1 = BUSY of the host-to-DSP doorbell. All its other bits are zero.
- R6: Each mask register keeps only bits 1:0, and its other bits read zero. Only the host port writes 0x28 and only the DSP port writes 0x30. A write to a mask from the other port is ignored.
- R7: host_irq is the OR of the host status bits whose mask bit is 0. dsp_irq is formed the same way from the DSP status and DSP mask. Both are valid right after the edge that updates a register.
- R8: If both ports write the host-to-DSP doorbell in the same cycle, bit 62 takes the DSP value and every other bit takes the host value.
- R9: If both ports write the DSP-to-host doorbell in the same cycle, bit 62 takes the host value and every other bit takes the DSP value.
- R10: Setting a mask bit drops the interrupt for that source while its status bit stays readable as 1. Clearing the mask bit raises the interrupt again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 8 | Host register byte address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data at host_addr |
| host_irq | output | 1 | Host level interrupt |
| dsp_we | input | 1 | DSP write enable |
| dsp_addr | input | 8 | DSP register byte address |
| dsp_wdata | input | 64 | DSP write data |
| dsp_rdata | output | 64 | DSP read data at dsp_addr |
| dsp_irq | output | 1 | DSP level interrupt |

## Verification
The bench drives a same-cycle write from both sides to each doorbell. A design that let one side win the whole word would lose either the receiver's DONE acknowledge or the sender's header and BUSY flag. It checks that a write from the wrong side to a mask and a write to a status register leave both unchanged. A design that decoded only the address, without the port, would mask the other side's interrupt. It walks the full mask, acknowledge and unmask sequence in both directions, so a status mirror wired to the wrong doorbell or to the wrong flag shows up as a missing or a stuck interrupt. A long run of pseudo-random writes from both ports is compared every cycle against a behavioural model.

// File: rtl/ipc_db_pkg.sv
package ipc_db_pkg;
   // register byte offsets shared by both ports
   localparam int OFS_HOST_STAT = 'h18;
   localparam int OFS_DSP_STAT  = 'h20;
   localparam int OFS_HOST_MASK = 'h28;
   localparam int OFS_DSP_MASK  = 'h30;
   localparam int OFS_H2D       = 'h38;
   localparam int OFS_D2H       = 'h40;
   // interrupt sources per side
   localparam int SRC_N    = 2;
   localparam int SRC_DONE = 0;
   localparam int SRC_BUSY = 1;
   // side indices
   localparam int SIDE_HOST = 0;
   localparam int SIDE_DSP  = 1;
   localparam int SIDE_N    = 2;
endpackage

// File: rtl/ipc_db_cell.sv
// One doorbell word written from two ports; on a collision the B port wins
// bit B_BIT and the A port wins every other bit.
module ipc_db_cell #(
   parameter int W     = 64,
   parameter int B_BIT = 62
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         a_we,
   input  logic [W-1:0] a_wd,
   input  logic         b_we,
   input  logic [W-1:0] b_wd,
   output logic [W-1:0] q
);
   if (B_BIT >= W || B_BIT < 0) begin : g_bad_bit
      $error("ipc_db_cell: B_BIT outside word");
   end

   localparam logic [W-1:0] B_OWN = {{(W-1){1'b0}}, 1'b1} << B_BIT;

   logic [W-1:0] take_a, take_b, nxt;

   always_comb begin
      take_a = {W{a_we}} & (~{W{b_we}} | ~B_OWN);
      take_b = {W{b_we}} & (~{W{a_we}} |  B_OWN);
      nxt    = (take_a & a_wd) | (take_b & b_wd) | (~(take_a | take_b) & q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R3: no write, no change
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_we && !b_we) |=> $stable(q));
endmodule

// File: rtl/ipc_db_side.sv
// Mask register and level interrupt for one side.
module ipc_db_side #(
   parameter int SRC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_we,
   input  logic [SRC_N-1:0] mask_wd,
   input  logic [SRC_N-1:0] src,
   output logic [SRC_N-1:0] mask_q,
   output logic             irq
);
   if (SRC_N < 1) begin : g_bad_src
      $error("ipc_db_side: SRC_N must be positive");
   end

   logic [SRC_N-1:0] live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_wd;
   end

   for (genvar i = 0; i < SRC_N; i++) begin : g_src
      assign live[i] = src[i] & ~mask_q[i];
   end

   assign irq = |live;

   // R10: fully masked side stays quiet
   p_mask_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq);
   // R7: an unmasked source that rises raises the interrupt
   p_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(src[0]) && !mask_q[0]) |-> irq);
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
   import ipc_db_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_irq,
   input  logic              dsp_we,
   input  logic [ADDR_W-1:0] dsp_addr,
   input  logic [DATA_W-1:0] dsp_wdata,
   output logic [DATA_W-1:0] dsp_rdata,
   output logic              dsp_irq
);
   localparam int BUSY = DATA_W - 1;
   localparam int DONE = DATA_W - 2;

   if (DATA_W < 4) begin : g_bad_w
      $error("ipc_doorbell: DATA_W too small");
   end
   if (ADDR_W < 7) begin : g_bad_a
      $error("ipc_doorbell: ADDR_W cannot reach the map");
   end

   logic hw_h2d, hw_d2h, dw_h2d, dw_d2h;
   logic [DATA_W-1:0] h2d_q, d2h_q;
   logic [SIDE_N-1:0] msk_we, irq;
   logic [SIDE_N-1:0][SRC_N-1:0] msk_wd, src, msk_q;

   assign hw_h2d = host_we && (host_addr == ADDR_W'(OFS_H2D));
   assign hw_d2h = host_we && (host_addr == ADDR_W'(OFS_D2H));
   assign dw_h2d = dsp_we  && (dsp_addr  == ADDR_W'(OFS_H2D));
   assign dw_d2h = dsp_we  && (dsp_addr  == ADDR_W'(OFS_D2H));

   // host-to-DSP: host owns BUSY and header, DSP owns DONE
   ipc_db_cell #(.W(DATA_W), .B_BIT(DONE)) u_h2d (
      .clk(clk), .rst_n(rst_n),
      .a_we(hw_h2d), .a_wd(host_wdata),
      .b_we(dw_h2d), .b_wd(dsp_wdata),
      .q(h2d_q));

   // DSP-to-host: DSP owns BUSY and header, host owns DONE
   ipc_db_cell #(.W(DATA_W), .B_BIT(DONE)) u_d2h (
      .clk(clk), .rst_n(rst_n),
      .a_we(dw_d2h), .a_wd(dsp_wdata),
      .b_we(hw_d2h), .b_wd(host_wdata),
      .q(d2h_q));

   always_comb begin
      src[SIDE_HOST][SRC_DONE] = h2d_q[DONE];
      src[SIDE_HOST][SRC_BUSY] = d2h_q[BUSY];
      src[SIDE_DSP][SRC_DONE]  = d2h_q[DONE];
      src[SIDE_DSP][SRC_BUSY]  = h2d_q[BUSY];
      msk_we[SIDE_HOST] = host_we && (host_addr == ADDR_W'(OFS_HOST_MASK));
      msk_we[SIDE_DSP]  = dsp_we  && (dsp_addr  == ADDR_W'(OFS_DSP_MASK));
      msk_wd[SIDE_HOST] = host_wdata[SRC_N-1:0];
      msk_wd[SIDE_DSP]  = dsp_wdata[SRC_N-1:0];
   end

   for (genvar s = 0; s < SIDE_N; s++) begin : g_side
      ipc_db_side #(.SRC_N(SRC_N)) u_side (
         .clk(clk), .rst_n(rst_n),
         .mask_we(msk_we[s]), .mask_wd(msk_wd[s]),
         .src(src[s]), .mask_q(msk_q[s]), .irq(irq[s]));
   end

   assign host_irq = irq[SIDE_HOST];
   assign dsp_irq  = irq[SIDE_DSP];

   function automatic logic [DATA_W-1:0] rd_mux(
      input logic [ADDR_W-1:0] a,
      input logic [SIDE_N-1:0][SRC_N-1:0] st,
      input logic [SIDE_N-1:0][SRC_N-1:0] mk,
      input logic [DATA_W-1:0] dh,
      input logic [DATA_W-1:0] hd);
      logic [DATA_W-1:0] r;
      r = '0;
      if (a == ADDR_W'(OFS_HOST_STAT)) r = DATA_W'(st[SIDE_HOST]);
      if (a == ADDR_W'(OFS_DSP_STAT))  r = DATA_W'(st[SIDE_DSP]);
      if (a == ADDR_W'(OFS_HOST_MASK)) r = DATA_W'(mk[SIDE_HOST]);
      if (a == ADDR_W'(OFS_DSP_MASK))  r = DATA_W'(mk[SIDE_DSP]);
      if (a == ADDR_W'(OFS_H2D))       r = dh;
      if (a == ADDR_W'(OFS_D2H))       r = hd;
      return r;
   endfunction

   always_comb begin
      host_rdata = rd_mux(host_addr, src, msk_q, h2d_q, d2h_q);
      dsp_rdata  = rd_mux(dsp_addr,  src, msk_q, h2d_q, d2h_q);
   end

   // R8: same-cycle writes to host-to-DSP doorbell
   p_owner_h2d_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_h2d && dw_h2d) |=> (h2d_q[BUSY] == $past(host_wdata[BUSY]) &&
                              h2d_q[DONE] == $past(dsp_wdata[DONE])));
   // R9: same-cycle writes to DSP-to-host doorbell
   p_owner_d2h_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_d2h && dw_d2h) |=> (d2h_q[BUSY] == $past(dsp_wdata[BUSY]) &&
                              d2h_q[DONE] == $past(host_wdata[DONE])));
   // R6: the DSP port never changes the host mask
   p_mask_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_we && host_addr == ADDR_W'(OFS_HOST_MASK)) |=> $stable(msk_q[SIDE_HOST]));
endmodule

// File: tb/ipc_doorbell_tb.sv
module ipc_doorbell_tb;
   localparam logic [63:0] BSY = 64'h8000_0000_0000_0000;
   localparam logic [63:0] DN  = 64'h4000_0000_0000_0000;
   localparam logic [63:0] ONES = '1;

   logic clk = 0, rst_n = 0;
   logic host_we = 0, dsp_we = 0;
   logic [7:0] host_addr = 0, dsp_addr = 0;
   logic [63:0] host_wdata = 0, dsp_wdata = 0;
   logic [63:0] host_rdata, dsp_rdata;
   logic host_irq, dsp_irq;
   int total = 0, bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   ipc_doorbell u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_irq(host_irq),
      .dsp_we(dsp_we), .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata),
      .dsp_rdata(dsp_rdata), .dsp_irq(dsp_irq));

   // behavioural reference model
   logic [63:0] m_h2d, m_d2h;
   logic [1:0] m_hm, m_dm;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_h2d <= 0; m_d2h <= 0; m_hm <= 0; m_dm <= 0;
      end else begin
         logic [63:0] n1, n2;
         bit h1, d1, h2, d2;
         n1 = m_h2d; n2 = m_d2h;
         h1 = host_we && host_addr == 8'h38; d1 = dsp_we && dsp_addr == 8'h38;
         h2 = host_we && host_addr == 8'h40; d2 = dsp_we && dsp_addr == 8'h40;
         for (int i = 0; i < 64; i++) begin
            if (h1 && d1) n1[i] = (i == 62) ? dsp_wdata[i] : host_wdata[i];
            else if (h1) n1[i] = host_wdata[i];
            else if (d1) n1[i] = dsp_wdata[i];
            if (h2 && d2) n2[i] = (i == 62) ? host_wdata[i] : dsp_wdata[i];
            else if (h2) n2[i] = host_wdata[i];
            else if (d2) n2[i] = dsp_wdata[i];
         end
         m_h2d <= n1; m_d2h <= n2;
         if (host_we && host_addr == 8'h28) m_hm <= host_wdata[1:0];
         if (dsp_we && dsp_addr == 8'h30) m_dm <= dsp_wdata[1:0];
      end
   end

   function automatic logic [63:0] exp_rd(logic [7:0] a);
      case (a)
         8'h18: return {62'b0, m_d2h[63], m_h2d[62]};
         8'h20: return {62'b0, m_h2d[63], m_d2h[62]};
         8'h28: return {62'b0, m_hm};
         8'h30: return {62'b0, m_dm};
         8'h38: return m_h2d;
         8'h40: return m_d2h;
         default: return 64'b0;
      endcase
   endfunction

   function automatic string tag_of(logic [7:0] a);
      case (a)
         8'h18: return "R4";
         8'h20: return "R5";
         8'h28, 8'h30: return "R6";
         8'h38, 8'h40: return "R3";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(tag_of(host_addr), host_rdata, exp_rd(host_addr));
         chk(tag_of(dsp_addr), dsp_rdata, exp_rd(dsp_addr));
         chk("R7 host_irq", 64'(host_irq),
             64'((m_h2d[62] & ~m_hm[0]) | (m_d2h[63] & ~m_hm[1])));
         chk("R7 dsp_irq", 64'(dsp_irq),
             64'((m_d2h[62] & ~m_dm[0]) | (m_h2d[63] & ~m_dm[1])));
      end
   end

   task automatic drive(bit hwe, logic [7:0] ha, logic [63:0] hd,
                        bit dwe, logic [7:0] da, logic [63:0] dd);
      @(posedge clk); #2;
      host_we = hwe; host_addr = ha; host_wdata = hd;
      dsp_we = dwe; dsp_addr = da; dsp_wdata = dd;
   endtask

   task automatic hwr(logic [7:0] a, logic [63:0] d); drive(1, a, d, 0, 8'h38, 0); endtask
   task automatic dwr(logic [7:0] a, logic [63:0] d); drive(0, 8'h38, 0, 1, a, d); endtask
   task automatic look(logic [7:0] ha, logic [7:0] da);
      drive(0, ha, 0, 0, da, 0);
      @(negedge clk); #1;
   endtask

   function automatic logic [7:0] pick(logic [2:0] k);
      case (k)
         3'd0: return 8'h18; 3'd1: return 8'h20; 3'd2: return 8'h28;
         3'd3: return 8'h30; 3'd4: return 8'h38; 3'd5: return 8'h40;
         3'd6: return 8'h50; default: return 8'h38;
      endcase
   endfunction

   task automatic summary();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL R1 watchdog act=hung exp=done");
         summary();
      end
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R1 reset state
      look(8'h38, 8'h40);
      chk("R1 h2d", host_rdata, 0); chk("R1 d2h", dsp_rdata, 0);
      chk("R1 host_irq", 64'(host_irq), 0); chk("R1 dsp_irq", 64'(dsp_irq), 0);
      look(8'h28, 8'h30);
      chk("R1 hmask", host_rdata, 0); chk("R1 dmask", dsp_rdata, 0);
      // host posts a message
      hwr(8'h38, BSY | 64'h123);
      look(8'h18, 8'h20);
      chk("R4 host stat", host_rdata, 0); chk("R5 dsp stat", dsp_rdata, 2);
      chk("R7 dsp_irq up", 64'(dsp_irq), 1); chk("R7 host_irq low", 64'(host_irq), 0);
      look(8'h38, 8'h38);
      chk("R3 h2d host", host_rdata, BSY | 64'h123); chk("R3 h2d dsp", dsp_rdata, BSY | 64'h123);
      // DSP masks busy
      dwr(8'h30, 64'h2);
      look(8'h30, 8'h20);
      chk("R2 host reads dmask", host_rdata, 2); chk("R10 status kept", dsp_rdata, 2);
      chk("R10 dsp_irq masked", 64'(dsp_irq), 0);
      // DSP replies
      dwr(8'h38, DN | 64'h123);
      look(8'h18, 8'h38);
      chk("R4 host done", host_rdata, 1); chk("R3 reply", dsp_rdata, DN | 64'h123);
      chk("R7 host_irq reply", 64'(host_irq), 1);
      hwr(8'h28, 64'h1);
      look(8'h18, 8'h20);
      chk("R10 host masked", 64'(host_irq), 0); chk("R10 host stat kept", host_rdata, 1);
      hwr(8'h38, 64'h123);
      hwr(8'h28, 64'h0);
      dwr(8'h30, 64'h0);
      look(8'h18, 8'h20);
      chk("R4 done cleared", host_rdata, 0); chk("R7 host_irq off", 64'(host_irq), 0);
      // wrong-side mask writes and read-only status
      dwr(8'h28, 64'h3);
      hwr(8'h30, 64'h3);
      look(8'h28, 8'h30);
      chk("R6 dsp->hmask ignored", host_rdata, 0); chk("R6 host->dmask ignored", dsp_rdata, 0);
      hwr(8'h28, ONES);
      look(8'h28, 8'h28);
      chk("R6 mask width", host_rdata, 3);
      hwr(8'h28, 64'h0);
      drive(1, 8'h18, ONES, 1, 8'h20, ONES);
      look(8'h18, 8'h20);
      chk("R2 hstat ro", host_rdata, 0); chk("R2 dstat ro", dsp_rdata, 0);
      drive(1, 8'h50, ONES, 1, 8'h08, ONES);
      look(8'h50, 8'h38);
      chk("R2 unmapped", host_rdata, 0); chk("R2 no side effect", dsp_rdata, 64'h123);
      // DSP posts a message
      dwr(8'h40, BSY | 64'h77);
      look(8'h18, 8'h20);
      chk("R4 host busy", host_rdata, 2); chk("R5 dsp stat", dsp_rdata, 0);
      chk("R7 host_irq busy", 64'(host_irq), 1);
      hwr(8'h28, 64'h2);
      look(8'h18, 8'h20);
      chk("R10 busy masked", 64'(host_irq), 0);
      hwr(8'h40, DN | 64'h77);
      look(8'h40, 8'h20);
      chk("R3 ack", host_rdata, DN | 64'h77); chk("R5 dsp done", dsp_rdata, 1);
      chk("R7 dsp_irq done", 64'(dsp_irq), 1);
      hwr(8'h28, 64'h0);
      dwr(8'h40, 64'h0);
      look(8'h18, 8'h20);
      chk("R7 both quiet h", 64'(host_irq), 0); chk("R7 both quiet d", 64'(dsp_irq), 0);
      // collisions
      drive(1, 8'h38, BSY | 64'hAB, 1, 8'h38, DN | 64'h12);
      look(8'h38, 8'h38);
      chk("R8 collision h2d", host_rdata, 64'hC000_0000_0000_00AB);
      drive(1, 8'h40, DN | 64'h99, 1, 8'h40, BSY | 64'h55);
      look(8'h40, 8'h40);
      chk("R9 collision d2h", dsp_rdata, 64'hC000_0000_0000_0055);
      drive(1, 8'h38, 64'h5, 1, 8'h38, ONES);
      look(8'h38, 8'h38);
      chk("R8 dsp clears busy lost", host_rdata, DN | 64'h5);
      // pseudo-random traffic checked against the model every cycle
      lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         logic [15:0] l2;
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         l2 = {lf[7:0], lf[15:8]} ^ 16'h5A3C;
         drive(lf[0], pick(lf[3:1]), {lf[7:6], 46'b0, lf},
               l2[0], pick(l2[3:1]), {l2[9:8], 46'b0, l2});
      end
      look(8'h18, 8'h20);
      summary();
   end
endmodule